// File: doc/BRIEF.md
# Floating-Point Rate Symbol Strobe Generator

This block turns a fast reference clock into a symbol-rate strobe. The rate is not a plain integer divider. It is a small floating-point pair: a mantissa `M` and an exponent `E`. On every enabled reference cycle, the value `(2^MANT_W + M)` shifted left by `E` is added into a modulo `2^ACC_W` phase accumulator. Each carry out of the accumulator's top bit produces a one-cycle pulse on `strobe_o`. With the default widths (8-bit mantissa, 4-bit exponent, 28-bit accumulator), the mean strobe rate is `(256 + M) * 2^E * f_ref / 2^28`. A 26 MHz reference then covers rates from well under 1 kBaud up to several hundred kBaud.

A serial modulator or demodulator uses the strobe as its symbol tick. Software may change `mant_i` and `exp_i` at any time. While the generator is enabled, a new pair is captured only in the same cycle that a carry occurs, so a running symbol period is never cut short or stretched by a change. While the generator is disabled, the accumulator is held at zero and the rate pair is captured continuously, so the first period after enabling already runs at the programmed rate.

Top module: `symrate_gen`

## Requirements
- R1: While reset is asserted, and after reset until the generator is enabled, `strobe_o` is 0.
- R2: On every clock edge with `en_i` high, the accumulator grows by `(2^MANT_W + M) << E`, using the captured mantissa and exponent, modulo `2^ACC_W`. A carry out of bit `ACC_W-1` at an edge makes `strobe_o` high for exactly the following cycle.
- R3: When the increment divides `2^ACC_W`, strobes are evenly spaced at `2^ACC_W / increment` cycles. For example, with `ACC_W=16`: M=0, E=0 gives 256 cycles, and M=0, E=2 gives 64 cycles.
- R4: While `en_i` is low, the accumulator is held at zero and `strobe_o` is 0 from the next cycle. After `en_i` rises, the first strobe follows after one full period counted from zero.
- R5: A change of `mant_i` or `exp_i` while enabled does not affect the current period. The new pair is captured at the edge that produces the next strobe, and it governs the periods after that.
- R6: While `en_i` is low, `mant_i` and `exp_i` are captured on every edge, so the period that starts when `en_i` rises uses the values present at that time.
- R7: If the increment is not smaller than `2^ACC_W`, every enabled edge carries, and `strobe_o` stays high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| en_i | input | 1 | Run enable; low holds the accumulator at zero |
| mant_i | input | MANT_W | Rate mantissa M |
| exp_i | input | EXP_W | Rate exponent E |
| strobe_o | output | 1 | One-cycle symbol strobe |

## Verification
The bench builds the block with `ACC_W=16`, keeping the default mantissa and exponent widths. With a 28-bit accumulator the slowest period would be about a million cycles. At 16 bits, periods of 256 cycles or fewer are reached, so many complete periods, mid-period rate changes and enable toggles fit into one run. Random exponents are kept to 0..6 so the increment stays below the modulus. One directed case uses exponent 15, which drives the increment past `2^16` and exercises the every-cycle carry case.

// File: rtl/symrate_pkg.sv
package symrate_pkg;
  // Width of the shifted increment (2^mw + M) << E for the largest E.
  function automatic int inc_width(input int mw, input int ew);
    return mw + 1 + (2 ** ew) - 1;
  endfunction

  // Width of the adder result, one bit above the wider operand.
  function automatic int sum_width(input int aw, input int iw);
    return ((aw > iw) ? aw : iw) + 1;
  endfunction
endpackage

// File: rtl/symrate_word.sv
module symrate_word #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wrap_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [MANT_W-1:0] mant_o,
  output logic [EXP_W-1:0]  exp_o
);
  logic              load;
  logic [MANT_W-1:0] mant_d, mant_q;
  logic [EXP_W-1:0]  exp_d, exp_q;

  // Capture continuously while idle, otherwise only on a wrap.
  always_comb begin
    load   = !en_i || wrap_i;
    mant_d = load ? mant_i : mant_q;
    exp_d  = load ? exp_i  : exp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_q <= '0;
      exp_q  <= '0;
    end else begin
      mant_q <= mant_d;
      exp_q  <= exp_d;
    end
  end

  assign mant_o = mant_q;
  assign exp_o  = exp_q;
endmodule

// File: rtl/symrate_inc.sv
module symrate_inc #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int INC_W  = symrate_pkg::inc_width(MANT_W, EXP_W)
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [INC_W-1:0]  inc_o
);
  // Hidden leading one gives (2^MANT_W + M), then scale by 2^E.
  assign inc_o = INC_W'({1'b1, mant_i}) << exp_i;
endmodule

// File: rtl/symrate_acc.sv
module symrate_acc #(
  parameter int ACC_W = 28,
  parameter int INC_W = 24,
  parameter int SUM_W = symrate_pkg::sum_width(ACC_W, INC_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic             wrap_o,
  output logic [ACC_W-1:0] acc_o,
  output logic             strobe_o
);
  logic [SUM_W-1:0] sum;
  logic [ACC_W-1:0] acc_d, acc_q;
  logic             strobe_d, strobe_q;

  always_comb begin
    sum      = SUM_W'(acc_q) + SUM_W'(inc_i);
    wrap_o   = en_i && (|sum[SUM_W-1:ACC_W]);
    acc_d    = en_i ? sum[ACC_W-1:0] : '0;
    strobe_d = wrap_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      strobe_q <= strobe_d;
    end
  end

  assign acc_o    = acc_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/symrate_gen.sv
module symrate_gen #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int ACC_W  = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic              strobe_o
);
  localparam int INC_W = symrate_pkg::inc_width(MANT_W, EXP_W);

  logic              wrap;
  logic [MANT_W-1:0] cur_mant;
  logic [EXP_W-1:0]  cur_exp;
  logic [INC_W-1:0]  inc;
  logic [ACC_W-1:0]  acc_q;

  symrate_word #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_word (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .wrap_i(wrap),
    .mant_i(mant_i),
    .exp_i (exp_i),
    .mant_o(cur_mant),
    .exp_o (cur_exp)
  );

  symrate_inc #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INC_W(INC_W)) u_inc (
    .mant_i(cur_mant),
    .exp_i (cur_exp),
    .inc_o (inc)
  );

  symrate_acc #(.ACC_W(ACC_W), .INC_W(INC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .inc_i   (inc),
    .wrap_o  (wrap),
    .acc_o   (acc_q),
    .strobe_o(strobe_o)
  );
endmodule

// File: rtl/symrate_gen_chk.sv
module symrate_gen_chk #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int ACC_W  = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              strobe_o,
  input logic [ACC_W-1:0]  acc_q,
  input logic [MANT_W-1:0] cur_mant,
  input logic [EXP_W-1:0]  cur_exp
);
  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !strobe_o);

  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0));

  // R5
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !strobe_o) |-> ($stable(cur_mant) && $stable(cur_exp)));

  // R2
  acc_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !strobe_o) |-> (acc_q > $past(acc_q)));
endmodule

bind symrate_gen symrate_gen_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W), .ACC_W(ACC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .strobe_o(strobe_o),
  .acc_q   (acc_q),
  .cur_mant(cur_mant),
  .cur_exp (cur_exp)
);

// File: tb/sim_symrate_gen.sv
module sim_symrate_gen;
  localparam int MW  = 8;
  localparam int EW  = 4;
  localparam int AW  = 16;
  localparam longint MOD = 64'd1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [MW-1:0] mant = '0;
  logic [EW-1:0] expo = '0;
  logic          strobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  symrate_gen #(.MANT_W(MW), .EXP_W(EW), .ACC_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .mant_i(mant), .exp_i(expo), .strobe_o(strobe)
  );

  // Reference model of the requirements
  longint m_acc;
  bit     m_strb;
  int     m_m, m_e;

  function automatic longint rate_inc(input int m, input int e);
    return longint'((1 << MW) + m) << e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_strb = 0; m_m = 0; m_e = 0;
    end else if (en) begin
      longint s;
      s = m_acc + rate_inc(m_m, m_e);
      m_strb = (s >= MOD);
      m_acc = s % MOD;
      if (m_strb) begin m_m = int'(mant); m_e = int'(expo); end
    end else begin
      m_acc = 0; m_strb = 0; m_m = int'(mant); m_e = int'(expo);
    end
  end

  // Per-cycle comparison against the model (R2, R5, R6)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (strobe !== m_strb) begin
        errors++;
        $display("FAIL R2 model: strobe=%0b expected=%0b at %0t", strobe, m_strb, $time);
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Cycles until the next strobe, counted in negedges
  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!strobe && n < 100000);
  endtask

  initial begin
    int g;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 in reset", longint'(strobe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after reset", longint'(strobe), 0);

    // R3: M=0 E=0 -> 256 cycles
    mant = 8'd0; expo = 4'd0;
    @(negedge clk); en = 1'b1;
    gap(g); check("R4 first period", g, 256);
    gap(g); check("R3 period 256", g, 256);
    @(negedge clk); check("R2 one-cycle pulse", longint'(strobe), 0);

    // R5: change mid-period, old period completes
    en = 1'b0; @(negedge clk);
    check("R4 idle no strobe", longint'(strobe), 0);
    mant = 8'd0; expo = 4'd0;
    @(negedge clk); en = 1'b1;
    repeat (10) @(negedge clk);
    expo = 4'd2;
    gap(g); check("R5 old period kept", g, 246);
    gap(g); check("R5 new period 64", g, 64);
    gap(g); check("R3 period 64", g, 64);

    // R6: loaded while idle
    en = 1'b0;
    repeat (3) @(negedge clk);
    expo = 4'd3;
    @(negedge clk); en = 1'b1;
    gap(g); check("R6 idle capture period 32", g, 32);

    // R4: idle holds zero - restart gives a full period
    repeat (7) @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 quiet while idle", longint'(strobe), 0);
    en = 1'b1;
    gap(g); check("R4 restart from zero", g, 32);

    // R7: increment beyond modulus
    en = 1'b0; expo = 4'd15; @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R7 every cycle", longint'(strobe), 1);
    end

    // Random phase checked by the model
    en = 1'b0; expo = 4'd0; @(negedge clk);
    for (int it = 0; it < 40; it++) begin
      mant = MW'($urandom_range(0, 255));
      expo = EW'($urandom_range(0, 6));
      en = ($urandom_range(0, 7) != 0);
      repeat ($urandom_range(50, 1500)) @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule